// File: doc/BRIEF.md
# Circular Buffer Address Stepper

This block computes the next value of a 16-bit address pointer that walks a circular buffer of arbitrary length M. Each cycle it receives the present pointer, a size word holding M-1, a two's-complement offset and a 3-bit operation code. It returns two registered results: the address to use for the current access and the value the pointer takes afterwards. Both are captured on the rising clock edge while the update enable is high.

The buffer has no separate base register. Its base comes from the pointer itself. The block size P is the smallest power of two that is not below M. The base is the pointer with its low log2(P) bits cleared, and the buffer occupies base .. base+M-1. A unit step crosses a buffer edge at most once. An offset step may be larger than the buffer in either direction, so the block reduces it modulo M before adding it to the in-buffer position. That keeps every result inside the buffer however many times the step wraps. Storage of pointers, the memory port and instruction decoding belong to the surrounding datapath.

Top module: `circ_addr_step`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets both next_ptr and eff_addr to 0.
- R2: While upd_en is low at a rising edge, next_ptr and eff_addr keep their values whatever the other inputs do.
- R3: Operation code 0 (step up after access) gives eff_addr = cur_ptr and next_ptr = cur_ptr+1, or the base when the in-buffer position equals M-1.
- R4: Operation code 1 (step down after access) gives eff_addr = cur_ptr and next_ptr = cur_ptr-1, or base+M-1 when cur_ptr is the base.
- R5: Operation code 2 (step down before access) loads both outputs with the wrapped decremented pointer from R4.
- R6: Operation code 3 (add offset after access) gives eff_addr = cur_ptr and next_ptr = base + ((pos + offset) mod M), where pos = cur_ptr - base and offset is signed 16-bit of any magnitude.
- R7: Operation code 4 (subtract offset after access) gives eff_addr = cur_ptr and next_ptr = base + ((pos - offset) mod M), with offset signed and of any magnitude, 0x8000 included.
- R8: Operation code 5 (indexed) gives eff_addr = base + ((pos + offset) mod M) and leaves next_ptr = cur_ptr.
- R9: The size word holds M-1, and the base is cur_ptr with its low log2(P) bits cleared, where P is the smallest power of two not below M. For a legal pointer (pos <= M-1) every result keeps this base and has pos < M. A size word of 0 therefore pins the pointer, and 0xFFFF wraps across the full 64K space.
- R10: Operation codes 6 and 7 give eff_addr = next_ptr = cur_ptr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Captures new results on this edge |
| mode | input | 3 | Operation code (0..7, see R3-R10) |
| cur_ptr | input | 16 | Present pointer value |
| modifier | input | 16 | Buffer length minus one |
| offset | input | 16 | Two's-complement step for codes 3, 4, 5 |
| next_ptr | output | 16 | Registered pointer after the operation |
| eff_addr | output | 16 | Registered address for this access |

## Verification
The properties assume a legal pointer, one whose position above the derived base does not exceed the size word. The checks on wrapping and base retention are gated on that condition and make no claim about pointers outside the buffer. The bench builds each random pointer from a random size word, a random multiple of the matching block size and a position below M, so every stimulus is legal. Offsets are fully random 16-bit values, and directed cases add the extreme offsets, the single-entry buffer and the full 64K buffer.

// File: rtl/circ_pkg.sv
package circ_pkg;

   typedef enum logic [2:0] {
      OP_STEP_UP    = 3'd0,
      OP_STEP_DN    = 3'd1,
      OP_PRE_DN     = 3'd2,
      OP_ADD_OFS    = 3'd3,
      OP_SUB_OFS    = 3'd4,
      OP_INDEXED    = 3'd5,
      OP_RSVD_A     = 3'd6,
      OP_RSVD_B     = 3'd7
   } op_e;

endpackage

// File: rtl/circ_window.sv
// Derives the power-of-two block mask, the base and the in-buffer position
module circ_window #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] cur_ptr,
   input  logic [AW-1:0] modifier,
   output logic [AW-1:0] mask,
   output logic [AW-1:0] base,
   output logic [AW-1:0] pos,
   output logic [AW:0]   m_len
);

   // a mask bit is set when the size word has any set bit at or above it
   for (genvar gi = 0; gi < AW; gi++) begin : g_smear
      assign mask[gi] = |(modifier >> gi);
   end

   assign base  = cur_ptr & ~mask;
   assign pos   = cur_ptr & mask;
   assign m_len = {1'b0, modifier} + {{AW{1'b0}}, 1'b1};

endmodule

// File: rtl/circ_unit_step.sv
// Single-wrap increment and decrement of the in-buffer position
module circ_unit_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] pos,
   input  logic [AW-1:0] limit,
   output logic [AW-1:0] up_pos,
   output logic [AW-1:0] dn_pos
);

   assign up_pos = (pos == limit)   ? '0    : AW'(pos + 1'b1);
   assign dn_pos = (pos == '0)      ? limit : AW'(pos - 1'b1);

endmodule

// File: rtl/circ_mod_reduce.sv
// Unsigned remainder num mod den by a restoring compare-subtract chain
module circ_mod_reduce #(
   parameter int NW = 17,
   parameter int MW = 17
) (
   input  logic [NW-1:0] num,
   input  logic [MW-1:0] den,
   output logic [MW-1:0] rem
);

   if (NW < 2 || MW < 2) begin : g_chk
      $error("circ_mod_reduce: widths too small");
   end

   logic [MW-1:0] stg [0:NW];
   assign stg[0] = '0;

   for (genvar gk = 0; gk < NW; gk++) begin : g_stage
      logic [MW:0] trial;
      logic        fits;
      assign trial = {stg[gk], num[NW-1-gk]};
      assign fits  = (trial >= {1'b0, den});
      assign stg[gk+1] = fits ? MW'(trial - {1'b0, den}) : MW'(trial);
   end

   assign rem = stg[NW];

endmodule

// File: rtl/circ_offset_wrap.sv
// Applies a signed offset of any size to the in-buffer position, modulo M
module circ_offset_wrap #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] pos,
   input  logic [AW:0]   m_len,
   input  logic [AW:0]   mag,
   input  logic          neg,
   output logic [AW-1:0] new_pos
);

   logic [AW:0] red;
   logic [AW:0] pos_x;
   logic [AW:0] sum;
   logic [AW:0] res;

   circ_mod_reduce #(.NW(AW+1), .MW(AW+1)) u_reduce (
      .num (mag),
      .den (m_len),
      .rem (red)
   );

   assign pos_x = {1'b0, pos};

   always_comb begin
      if (!neg) begin
         sum = pos_x + red;
         res = (sum >= m_len) ? (sum - m_len) : sum;
      end else begin
         sum = pos_x + m_len;
         res = (pos_x >= red) ? (pos_x - red) : (sum - red);
      end
   end

   assign new_pos = AW'(res);

endmodule

// File: rtl/circ_addr_step.sv
module circ_addr_step #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          upd_en,
   input  logic [2:0]    mode,
   input  logic [AW-1:0] cur_ptr,
   input  logic [AW-1:0] modifier,
   input  logic [AW-1:0] offset,
   output logic [AW-1:0] next_ptr,
   output logic [AW-1:0] eff_addr
);
   import circ_pkg::*;

   if (AW < 4 || AW > 30) begin : g_chk
      $error("circ_addr_step: AW out of range");
   end

   logic [AW-1:0] mask, base, pos;
   logic [AW:0]   m_len;
   logic [AW-1:0] up_pos, dn_pos, ofs_pos;
   logic [AW:0]   mag;
   logic          neg;
   logic [AW-1:0] nxt_d, eff_d;
   op_e           op;

   assign op = op_e'(mode);

   circ_window #(.AW(AW)) u_window (
      .cur_ptr  (cur_ptr),
      .modifier (modifier),
      .mask     (mask),
      .base     (base),
      .pos      (pos),
      .m_len    (m_len)
   );

   circ_unit_step #(.AW(AW)) u_unit (
      .pos    (pos),
      .limit  (modifier),
      .up_pos (up_pos),
      .dn_pos (dn_pos)
   );

   // magnitude and direction of the offset step
   assign mag = offset[AW-1] ? ({1'b0, ~offset} + {{AW{1'b0}}, 1'b1})
                             : {1'b0, offset};
   assign neg = (op == OP_SUB_OFS) ? ~offset[AW-1] : offset[AW-1];

   circ_offset_wrap #(.AW(AW)) u_ofs (
      .pos     (pos),
      .m_len   (m_len),
      .mag     (mag),
      .neg     (neg),
      .new_pos (ofs_pos)
   );

   always_comb begin
      eff_d = cur_ptr;
      nxt_d = cur_ptr;
      case (op)
         OP_STEP_UP: nxt_d = base | up_pos;
         OP_STEP_DN: nxt_d = base | dn_pos;
         OP_PRE_DN: begin
            nxt_d = base | dn_pos;
            eff_d = base | dn_pos;
         end
         OP_ADD_OFS,
         OP_SUB_OFS: nxt_d = base | ofs_pos;
         OP_INDEXED: eff_d = base | ofs_pos;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         next_ptr <= '0;
         eff_addr <= '0;
      end else if (upd_en) begin
         next_ptr <= nxt_d;
         eff_addr <= eff_d;
      end
   end

   // ---------------- assertions ----------------
   logic legal;
   assign legal = (pos <= modifier);

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (next_ptr == '0 && eff_addr == '0));

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !upd_en |=> ($stable(next_ptr) && $stable(eff_addr)));

   p_up_plain_r3: assert property (@(posedge clk) disable iff (rst)
      (upd_en && op == OP_STEP_UP && legal && pos != modifier)
      |=> next_ptr == AW'($past(cur_ptr) + 1'b1));

   p_dn_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (upd_en && op == OP_STEP_DN && legal && pos == '0)
      |=> next_ptr == AW'($past(cur_ptr) + $past(modifier)));

   p_pre_dn_same_r5: assert property (@(posedge clk) disable iff (rst)
      (upd_en && op == OP_PRE_DN) |=> next_ptr == eff_addr);

   p_idx_keep_r8: assert property (@(posedge clk) disable iff (rst)
      (upd_en && op == OP_INDEXED) |=> next_ptr == $past(cur_ptr));

   p_keep_base_r9: assert property (@(posedge clk) disable iff (rst)
      (upd_en && legal)
      |=> ((next_ptr & ~$past(mask)) == $past(base)
           && (eff_addr & ~$past(mask)) == $past(base)
           && (next_ptr & $past(mask)) <= $past(modifier)
           && (eff_addr & $past(mask)) <= $past(modifier)));

   p_rsvd_pass_r10: assert property (@(posedge clk) disable iff (rst)
      (upd_en && (op == OP_RSVD_A || op == OP_RSVD_B))
      |=> (next_ptr == $past(cur_ptr) && eff_addr == $past(cur_ptr)));

endmodule

// File: tb/circ_addr_step_tb.sv
`timescale 1ns/1ps
module circ_addr_step_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        upd_en = 1'b0;
   logic [2:0]  mode = '0;
   logic [15:0] cur_ptr = '0;
   logic [15:0] modifier = '0;
   logic [15:0] offset = '0;
   logic [15:0] next_ptr, eff_addr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   circ_addr_step #(.AW(16)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .upd_en   (upd_en),
      .mode     (mode),
      .cur_ptr  (cur_ptr),
      .modifier (modifier),
      .offset   (offset),
      .next_ptr (next_ptr),
      .eff_addr (eff_addr)
   );

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // base + ((pos + delta) mod M), computed arithmetically
   function automatic logic [15:0] wrap_to(input logic [15:0] ptr, input logic [15:0] md,
                                           input int delta);
      int m, p, b, ps, r;
      m = int'(md) + 1;
      p = 1;
      while (p < m) p = p * 2;
      ps = int'(ptr) % p;
      b = int'(ptr) - ps;
      r = (ps + delta) % m;
      if (r < 0) r = r + m;
      return 16'(b + r);
   endfunction

   function automatic string tag_of(input logic [2:0] md);
      case (md)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R10";
      endcase
   endfunction

   // drive one operation, capture it, and check against the model
   task automatic apply(input logic en, input logic [2:0] md, input logic [15:0] ptr,
                        input logic [15:0] mdf, input logic [15:0] ofs, input string tag);
      logic [15:0] old_nxt, old_eff, exp_nxt, exp_eff, dn;
      int so;
      @(negedge clk);
      old_nxt = next_ptr;
      old_eff = eff_addr;
      upd_en = en; mode = md; cur_ptr = ptr; modifier = mdf; offset = ofs;
      so = int'($signed(ofs));
      dn = wrap_to(ptr, mdf, -1);
      exp_eff = ptr;
      exp_nxt = ptr;
      case (md)
         3'd0: exp_nxt = wrap_to(ptr, mdf, 1);
         3'd1: exp_nxt = dn;
         3'd2: begin exp_nxt = dn; exp_eff = dn; end
         3'd3: exp_nxt = wrap_to(ptr, mdf, so);
         3'd4: exp_nxt = wrap_to(ptr, mdf, -so);
         3'd5: exp_eff = wrap_to(ptr, mdf, so);
         default: ;
      endcase
      if (!en) begin
         exp_nxt = old_nxt;
         exp_eff = old_eff;
      end
      @(posedge clk);
      #1;
      chk({tag, " next_ptr"}, next_ptr, exp_nxt);
      chk({tag, " eff_addr"}, eff_addr, exp_eff);
   endtask

   initial begin
      logic [15:0] md, ptr;
      int m, p, b;
      void'($urandom(32'd7331));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset next_ptr", next_ptr, 16'h0000);
      chk("R1 reset eff_addr", eff_addr, 16'h0000);
      @(negedge clk);
      rst = 1'b0;

      // directed corners, 32-entry buffer at base 160
      apply(1'b1, 3'd0, 16'd191, 16'd31, 16'd0, "R3 wrap to base");
      apply(1'b1, 3'd0, 16'd175, 16'd31, 16'd0, "R3 plain step");
      apply(1'b1, 3'd1, 16'd160, 16'd31, 16'd0, "R4 wrap to top");
      apply(1'b1, 3'd2, 16'd160, 16'd31, 16'd0, "R5 pre-step wrap");
      apply(1'b1, 3'd3, 16'd170, 16'd31, 16'd100, "R6 multi-wrap add");
      apply(1'b1, 3'd4, 16'd170, 16'd31, 16'h8000, "R7 most negative offset");
      apply(1'b1, 3'd3, 16'd170, 16'd31, 16'h7FFF, "R6 most positive offset");
      // 20-entry buffer: block size 32, base 64
      apply(1'b1, 3'd0, 16'd83, 16'd19, 16'd0, "R9 non power of two wrap");
      apply(1'b1, 3'd5, 16'd70, 16'd19, 16'hFFF0, "R8 indexed negative");
      apply(1'b1, 3'd4, 16'd70, 16'd19, 16'd45, "R7 subtract multi-wrap");
      apply(1'b1, 3'd3, 16'd1234, 16'd0, 16'd7, "R9 single entry pinned");
      apply(1'b1, 3'd0, 16'hFFFF, 16'hFFFF, 16'd0, "R9 full space wrap");
      apply(1'b1, 3'd6, 16'd300, 16'd63, 16'd5, "R10 code 6");
      apply(1'b1, 3'd7, 16'd301, 16'd63, 16'd5, "R10 code 7");
      apply(1'b0, 3'd0, 16'd999, 16'd31, 16'd3, "R2 hold");

      // constrained random: legal pointers, any offset
      for (int i = 0; i < 800; i++) begin
         md = 16'(($urandom & 32'hFFFF) & ((32'd1 << ($urandom % 17)) - 1));
         m = int'(md) + 1;
         p = 1;
         while (p < m) p = p * 2;
         b = int'($urandom % (32'd65536 / p)) * p;
         ptr = 16'(b + int'($urandom % m));
         apply(($urandom % 5) != 0, 3'($urandom % 8), ptr, md, 16'($urandom),
               tag_of(mode));
      end

      // reset in mid run
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 late reset next_ptr", next_ptr, 16'h0000);
      chk("R1 late reset eff_addr", eff_addr, 16'h0000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule